// File: doc/BRIEF.md
# Idle Standby and Read Timing Controller

This block governs the enable and read-enable lines of a non-volatile memory cell while the surrounding controller is in its manual-read mode. A requester asks for reads with a level request and waits on a ready signal. The block counts the cycles in which the cell is enabled but nobody asks for a read. Once that count passes a programmable threshold, the cell is switched off to save power, while read mode stays selected. A threshold of zero turns this saving off.

Each time the cell is switched on, ready stays low until a programmable wake-up interval has elapsed. This holds when read mode is entered and when a request arrives while the cell is in standby. A read-enable pulse lasts one cycle. The read-enable low time between two pulses is normally one cycle. When the fast-access count is 1 and the gap-protection bit is set, that low time is stretched to two cycles by inserting a wait state.

The state machine has six states:
- OFF: read mode is not selected.
- WAKE: the cell is on and the wake-up time is running.
- IDLE: the cell is on and ready is high.
- READ: read-enable is high.
- GAP: an extra read-enable low cycle.
- STBY: the cell is off and read mode is still selected.

Transitions:
- OFF to WAKE when the mode is selected.
- WAKE to IDLE when the wake count is reached.
- IDLE to READ on a request.
- IDLE to STBY when the idle count expires.
- READ to GAP when protection applies, and READ to IDLE otherwise.
- GAP to IDLE.
- STBY to WAKE on a request.
- Any state to OFF when the mode is deselected.

Top module: `rdt_standby_ctrl`

## Requirements
- R1: While in reset, and while `rd_mode` is 0, `cell_en`, `cell_rd_en` and `ready` are all 0.
- R2: After `rd_mode` rises, `cell_en` is 1 and `ready` is 0 for exactly `cfg_wake`+1 cycles, and then `ready` becomes 1.
- R3: A request accepted at a clock edge (`req` and `ready` both 1) produces exactly one cycle of `cell_rd_en`=1 in the next cycle, with `ready`=0 in that cycle.
- R4: Without protection, `cell_rd_en` is low for exactly one cycle after a pulse, `ready` is 1 in that cycle, and with `req` held high the pulses repeat every 2 cycles.
- R5: When `cfg_fast`==1 and `cfg_prot`==1, `cell_rd_en` stays low for two cycles after each pulse, `ready` is 0 in the first of them, and with `req` held high the pulses repeat every 3 cycles.
- R6: When `cfg_fast`!=1, `cfg_prot` has no effect: the timing of R4 applies.
- R7: With `cfg_thr`>0, when the block is in the ready state with no request, `cell_en` falls after exactly `cfg_thr`+1 consecutive ready cycles. `rd_mode` stays 1 throughout.
- R8: With `cfg_thr`==0, `cell_en` stays 1 for as long as `rd_mode` is 1.
- R9: A request held while the cell is in standby re-enables the cell. `ready` then stays 0 for exactly `cfg_wake`+1 cycles before the request is accepted.
- R10: Clearing `rd_mode` drives `cell_en` and `ready` to 0 in the next cycle. Re-entering read mode, even after an aborted wake-up, waits the full wake-up time again.
- R11: The idle count restarts on every accepted request. A request in the last idle cycle is served, and the next standby needs a fresh `cfg_thr`+1 idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_mode | input | 1 | Manual-read mode selected |
| req | input | 1 | Read request, held until accepted |
| cfg_thr | input | THR_W | Idle threshold in cycles; 0 disables standby |
| cfg_wake | input | WAKE_W | Wake-up wait count minus one |
| cfg_fast | input | FAST_W | Fast-access count; protection applies only when it is 1 |
| cfg_prot | input | 1 | Two-cycle read-enable gap protection |
| ready | output | 1 | Request will be accepted at the next edge |
| cell_en | output | 1 | Memory cell enable |
| cell_rd_en | output | 1 | Memory cell read enable |

## Verification
The bench sweeps every combination of three wake-up counts (0, 2, 5), three idle thresholds (0, 1, 3), three fast-access counts (0, 1, 2) and both values of the protection bit. In each combination it runs an isolated read and a stream of reads with the request held high. The isolated read separates the one-cycle gap from the two-cycle gap. The stream measures the pulse period, which shows whether a wait state was inserted and whether protection was wrongly applied when the fast count is not 1. Idle runs measure the exact standby delay, and a request in the final idle cycle shows that the counter restarts. Requests issued in standby, and mode exits in the middle of a wake-up, check that every enable of the cell pays the full wake-up time.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_WAKE = 3'd1,
        ST_IDLE = 3'd2,
        ST_READ = 3'd3,
        ST_GAP  = 3'd4,
        ST_STBY = 3'd5
    } rdt_state_e;
endpackage

// File: rtl/rdt_wake_timer.sv
module rdt_wake_timer #(
    parameter int WAKE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [WAKE_W-1:0] limit,
    output logic              done
);
    logic [WAKE_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || done)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == limit);
endmodule

// File: rtl/rdt_idle_monitor.sv
module rdt_idle_monitor #(
    parameter int THR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [THR_W-1:0] thr,
    output logic             expired
);
    logic [THR_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (cnt != thr)
            cnt <= cnt + 1'b1;
    end

    assign expired = (thr != '0) && (cnt == thr);
endmodule

// File: rtl/rdt_standby_ctrl.sv
module rdt_standby_ctrl
    import rdt_pkg::*;
#(
    parameter int THR_W  = 10,
    parameter int WAKE_W = 8,
    parameter int FAST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_mode,
    input  logic              req,
    input  logic [THR_W-1:0]  cfg_thr,
    input  logic [WAKE_W-1:0] cfg_wake,
    input  logic [FAST_W-1:0] cfg_fast,
    input  logic              cfg_prot,
    output logic              ready,
    output logic              cell_en,
    output logic              cell_rd_en
);
    localparam logic [FAST_W-1:0] FAST_ONE = FAST_W'(1);

    rdt_state_e state, nxt;
    logic       wake_done;
    logic       idle_expired;
    logic       idle_clr;
    logic       gap_two;

    assign gap_two  = cfg_prot && (cfg_fast == FAST_ONE);
    assign idle_clr = (state != ST_IDLE) || req;

    rdt_wake_timer #(.WAKE_W(WAKE_W)) u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_WAKE),
        .limit (cfg_wake),
        .done  (wake_done)
    );

    rdt_idle_monitor #(.THR_W(THR_W)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (idle_clr),
        .thr     (cfg_thr),
        .expired (idle_expired)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_OFF;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:  nxt = ST_WAKE;
            ST_WAKE: if (wake_done) nxt = ST_IDLE;
            ST_IDLE: begin
                if (req)               nxt = ST_READ;
                else if (idle_expired) nxt = ST_STBY;
            end
            ST_READ: nxt = gap_two ? ST_GAP : ST_IDLE;
            ST_GAP:  nxt = ST_IDLE;
            ST_STBY: if (req) nxt = ST_WAKE;
            default: nxt = ST_OFF;
        endcase
        if (!rd_mode)
            nxt = ST_OFF;
    end

    always_comb begin
        ready      = 1'b0;
        cell_en    = 1'b0;
        cell_rd_en = 1'b0;
        unique case (state)
            ST_OFF:  ;
            ST_WAKE: cell_en = 1'b1;
            ST_IDLE: begin
                cell_en = 1'b1;
                ready   = 1'b1;
            end
            ST_READ: begin
                cell_en    = 1'b1;
                cell_rd_en = 1'b1;
            end
            ST_GAP:  cell_en = 1'b1;
            ST_STBY: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/rdt_standby_ctrl_chk.sv
module rdt_standby_ctrl_chk #(
    parameter int FAST_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_mode,
    input logic              req,
    input logic [FAST_W-1:0] cfg_fast,
    input logic              cfg_prot,
    input logic              ready,
    input logic              cell_en,
    input logic              cell_rd_en
);
    assert_off_when_mode_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_mode |=> (!cell_en && !ready && !cell_rd_en));

    assert_ready_needs_cell_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> cell_en);

    assert_accept_pulses_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready && rd_mode) |=> (cell_rd_en && !ready));

    assert_rden_needs_cell_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cell_rd_en |-> cell_en);

    assert_min_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cell_rd_en |=> !cell_rd_en);

    assert_protected_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fast == FAST_W'(1) && cfg_prot && $past(cell_rd_en)) |-> (!ready && !cell_rd_en));
endmodule

bind rdt_standby_ctrl rdt_standby_ctrl_chk #(.FAST_W(FAST_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_mode    (rd_mode),
    .req        (req),
    .cfg_fast   (cfg_fast),
    .cfg_prot   (cfg_prot),
    .ready      (ready),
    .cell_en    (cell_en),
    .cell_rd_en (cell_rd_en)
);

// File: tb/rdt_standby_ctrl_tb.sv
`timescale 1ns/1ps
module rdt_standby_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_mode = 1'b0;
    logic       req = 1'b0;
    logic [9:0] cfg_thr = '0;
    logic [7:0] cfg_wake = '0;
    logic [3:0] cfg_fast = '0;
    logic       cfg_prot = 1'b0;
    logic       ready, cell_en, cell_rd_en;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rdt_standby_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .rd_mode(rd_mode), .req(req),
        .cfg_thr(cfg_thr), .cfg_wake(cfg_wake), .cfg_fast(cfg_fast), .cfg_prot(cfg_prot),
        .ready(ready), .cell_en(cell_en), .cell_rd_en(cell_rd_en)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (wake=%0d thr=%0d fast=%0d prot=%0d)",
                     tag, act, exp, cfg_wake, cfg_thr, cfg_fast, cfg_prot);
        end
    endtask

    task automatic wait_ready();
        int k = 0;
        while (!ready && k < 100) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic count_wake(input int w, input string tag);
        int n = 0;
        int k = 0;
        while (k < 600) begin
            @(negedge clk);
            k++;
            if (ready) break;
            if (cell_en) n++;
        end
        chk(n == w + 1 && ready, tag, n, w + 1);
    endtask

    task automatic single_read(input bit gap2, input string tag);
        req = 1'b1;
        @(negedge clk);
        chk(cell_rd_en && !ready, "R3", {cell_rd_en, ready}, 2);
        req = 1'b0;
        @(negedge clk);
        chk(!cell_rd_en, tag, cell_rd_en, 0);
        chk(ready == !gap2, tag, ready, !gap2);
        if (gap2) begin
            @(negedge clk);
            chk(ready && !cell_rd_en, tag, ready, 1);
        end
    endtask

    task automatic stream_gap(input bit gap2, input string tag);
        int n = 0;
        req = 1'b1;
        @(negedge clk);
        chk(cell_rd_en, "R3", cell_rd_en, 1);
        while (n < 10) begin
            @(negedge clk);
            n++;
            if (cell_rd_en) break;
        end
        chk(n == (gap2 ? 3 : 2), tag, n, gap2 ? 3 : 2);
        req = 1'b0;
        @(negedge clk);
        wait_ready();
    endtask

    task automatic standby_count(input int thr, input string tag);
        int n = 1;
        while (n < 1200) begin
            @(negedge clk);
            if (!cell_en) break;
            n++;
        end
        chk(n == thr + 1 && !cell_en && !ready && rd_mode, tag, n, thr + 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired (R1..)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int wv[3] = '{0, 2, 5};
        int tv[3] = '{0, 1, 3};
        repeat (3) @(negedge clk);
        chk(!cell_en && !cell_rd_en && !ready, "R1", {cell_en, cell_rd_en, ready}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!cell_en && !cell_rd_en && !ready, "R1", {cell_en, cell_rd_en, ready}, 0);

        foreach (wv[i]) begin
            foreach (tv[j]) begin
                for (int f = 0; f < 3; f++) begin
                    for (int p = 0; p < 2; p++) begin
                        bit    gap2;
                        string gtag;
                        rd_mode  = 1'b0;
                        req      = 1'b0;
                        cfg_wake = 8'(wv[i]);
                        cfg_thr  = 10'(tv[j]);
                        cfg_fast = 4'(f);
                        cfg_prot = p[0];
                        gap2 = (f == 1) && (p == 1);
                        gtag = gap2 ? "R5" : (p == 1 ? "R6" : "R4");
                        @(negedge clk);
                        chk(!cell_en && !ready, "R1", {cell_en, ready}, 0);

                        if (wv[i] >= 2) begin
                            rd_mode = 1'b1;
                            @(negedge clk);
                            @(negedge clk);
                            rd_mode = 1'b0;
                            @(negedge clk);
                            chk(!cell_en && !ready, "R10", {cell_en, ready}, 0);
                        end

                        rd_mode = 1'b1;
                        count_wake(wv[i], (wv[i] >= 2) ? "R10" : "R2");
                        single_read(gap2, gtag);
                        stream_gap(gap2, gtag);

                        if (tv[j] == 0) begin
                            int drops = 0;
                            repeat (40) begin
                                @(negedge clk);
                                if (!cell_en) drops++;
                            end
                            chk(drops == 0, "R8", drops, 0);
                        end else begin
                            standby_count(tv[j], "R7");
                            req = 1'b1;
                            count_wake(wv[i], "R9");
                            @(negedge clk);
                            chk(cell_rd_en, "R9", cell_rd_en, 1);
                            req = 1'b0;
                            @(negedge clk);
                            wait_ready();
                            if (tv[j] >= 2) begin
                                repeat (tv[j]) @(negedge clk);
                                chk(cell_en && ready, "R11", {cell_en, ready}, 3);
                                req = 1'b1;
                                @(negedge clk);
                                chk(cell_rd_en, "R11", cell_rd_en, 1);
                                req = 1'b0;
                                @(negedge clk);
                                wait_ready();
                                standby_count(tv[j], "R11");
                            end
                        end

                        rd_mode = 1'b0;
                        @(negedge clk);
                        chk(!cell_en && !ready && !cell_rd_en, "R10", {cell_en, ready}, 0);
                    end
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule